// File: doc/BRIEF.md
# Code and Data Access Router

This block belongs to a small 8-bit controller that keeps code and data in separate address spaces. It decides, for every instruction fetch and every external-data request, whether the on-chip memory answers or the external bus must run a cycle. The memories, the CPU core and the bus sequencing sit outside the block. It only produces the select signals.

The code decision depends on a mode latched from the external-access pin while reset is held. With the mode set, every fetch goes off-chip. With the mode clear, fetches below the on-chip code size stay internal and all higher fetches go out.

On the data side, a window at the bottom of the external data space can be overlaid by on-chip auxiliary RAM. A disable bit returns that window to the external bus. Data routing does not depend on the latched code mode. The on-chip code size and the auxiliary window size are parameters, and a window size of 0 removes the overlay. All selects are combinational from the addresses and the latched mode, so they are valid in the same cycle as the request.

Top module: `access_router`

## Requirements
- R1: When extAccessPin (active high) was 1 at the last clock edge with rstN low, codeExtSel is 1 for every fetchAddr from 16'h0000 to 16'hFFFF.
- R2: When extAccessPin was 0 at the last clock edge with rstN low, codeExtSel is 0 for fetchAddr below 16'h1000 and 1 for fetchAddr 16'h1000 and above. This uses the default on-chip code size of 4096 bytes.
- R3: The mode is taken from extAccessPin on each rising clk edge while rstN is 0. After rstN goes high it holds until the next reset, whatever extAccessPin does.
- R4: The data selects are the same whichever code mode was latched.
- R5: With dataValid=1 and auxRamOff=0, a dataAddr below 768 (the default auxiliary size) gives dataAuxSel=1 and dataExtSel=0.
- R6: With dataValid=1, a dataAddr of 768 or above gives dataExtSel=1 and dataAuxSel=0, whatever the value of auxRamOff.
- R7: With dataValid=1 and auxRamOff=1, every dataAddr gives dataExtSel=1 and dataAuxSel=0.
- R8: With dataValid=0, both dataAuxSel and dataExtSel are 0. This also holds during reset.
- R9: The selects follow changes of fetchAddr and dataAddr in the same cycle, with no register stage on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low. The mode is latched while it is low |
| extAccessPin | input | 1 | External-access mode pin, 1 = fetch all code externally |
| fetchAddr | input | 16 | Instruction fetch address |
| dataValid | input | 1 | External-data request strobe |
| dataAddr | input | 16 | External-data request address |
| auxRamOff | input | 1 | 1 = auxiliary window is served by the external bus |
| codeExtSel | output | 1 | 1 = current fetch goes to the external bus |
| dataAuxSel | output | 1 | 1 = current data request is served by on-chip auxiliary RAM |
| dataExtSel | output | 1 | 1 = current data request goes to the external bus |

## Verification
The bench checks the edges of both ranges: fetches at 0FFFH and 1000H, and data at 767 and 768. A comparator that is off by one would move exactly one of these addresses to the wrong side. After each reset the bench flips extAccessPin. A mode register that keeps sampling the pin would then flip its code routing. The bench runs the same data pattern under both code modes and with the disable bit set, which shows up a data path that wrongly depends on the mode. It also sends requests with the strobe low, which shows up selects that fire without a request.

// File: rtl/access_router_pkg.sv
package access_router_pkg;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic extMode;   // latched external-access mode
    logic auxOn;     // auxiliary overlay enabled
    logic dataReq;   // a data request is present
  } routeStrobes_t;

endpackage

// File: rtl/access_router_ctrl.sv
module access_router_ctrl
  import access_router_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          extAccessPin,
  input  logic          dataValid,
  input  logic          auxRamOff,
  output routeStrobes_t strb
);

  logic extModeQ;

  // Track the pin only while reset is held; freeze once released.
  always_ff @(posedge clk) begin
    if (!rstN) extModeQ <= extAccessPin;
  end

  always_comb begin
    strb.extMode = extModeQ;
    strb.auxOn   = ~auxRamOff;
    strb.dataReq = dataValid;
  end

endmodule

// File: rtl/access_router_dp.sv
module access_router_dp
  import access_router_pkg::*;
#(
  parameter int CODE_ADDR_W       = 16,
  parameter int DATA_ADDR_W       = 16,
  parameter int ONCHIP_CODE_BYTES = 4096,
  parameter int AUX_RAM_BYTES     = 768
) (
  input  routeStrobes_t          strb,
  input  logic [CODE_ADDR_W-1:0] fetchAddr,
  input  logic [DATA_ADDR_W-1:0] dataAddr,
  output logic                   codeExtSel,
  output logic                   dataAuxSel,
  output logic                   dataExtSel
);

  localparam logic [CODE_ADDR_W:0] CODE_LIMIT = (CODE_ADDR_W+1)'(ONCHIP_CODE_BYTES);
  localparam logic [DATA_ADDR_W:0] AUX_LIMIT  = (DATA_ADDR_W+1)'(AUX_RAM_BYTES);

  logic codeInRange;
  logic dataInWindow;

  generate
    if (ONCHIP_CODE_BYTES == 0) begin : g_noCode
      assign codeInRange = 1'b0;
    end else begin : g_code
      assign codeInRange = ({1'b0, fetchAddr} < CODE_LIMIT);
    end

    if (AUX_RAM_BYTES == 0) begin : g_noAux
      assign dataInWindow = 1'b0;
    end else begin : g_aux
      assign dataInWindow = ({1'b0, dataAddr} < AUX_LIMIT);
    end
  endgenerate

  logic auxHit;

  always_comb begin
    auxHit     = dataInWindow & strb.auxOn;
    codeExtSel = strb.extMode | ~codeInRange;
    dataAuxSel = strb.dataReq & auxHit;
    dataExtSel = strb.dataReq & ~auxHit;
  end

endmodule

// File: rtl/access_router.sv
module access_router
  import access_router_pkg::*;
#(
  parameter int CODE_ADDR_W       = 16,
  parameter int DATA_ADDR_W       = 16,
  parameter int ONCHIP_CODE_BYTES = 4096,
  parameter int AUX_RAM_BYTES     = 768
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   extAccessPin,
  input  logic [CODE_ADDR_W-1:0] fetchAddr,
  input  logic                   dataValid,
  input  logic [DATA_ADDR_W-1:0] dataAddr,
  input  logic                   auxRamOff,
  output logic                   codeExtSel,
  output logic                   dataAuxSel,
  output logic                   dataExtSel
);

  routeStrobes_t routeStrb;

  access_router_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .extAccessPin (extAccessPin),
    .dataValid    (dataValid),
    .auxRamOff    (auxRamOff),
    .strb         (routeStrb)
  );

  access_router_dp #(
    .CODE_ADDR_W       (CODE_ADDR_W),
    .DATA_ADDR_W       (DATA_ADDR_W),
    .ONCHIP_CODE_BYTES (ONCHIP_CODE_BYTES),
    .AUX_RAM_BYTES     (AUX_RAM_BYTES)
  ) i_dp (
    .strb       (routeStrb),
    .fetchAddr  (fetchAddr),
    .dataAddr   (dataAddr),
    .codeExtSel (codeExtSel),
    .dataAuxSel (dataAuxSel),
    .dataExtSel (dataExtSel)
  );

endmodule

// File: rtl/access_router_chk.sv
module access_router_chk #(
  parameter int CODE_ADDR_W       = 16,
  parameter int DATA_ADDR_W       = 16,
  parameter int ONCHIP_CODE_BYTES = 4096,
  parameter int AUX_RAM_BYTES     = 768
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   modeQ,
  input logic [CODE_ADDR_W-1:0] fetchAddr,
  input logic                   dataValid,
  input logic [DATA_ADDR_W-1:0] dataAddr,
  input logic                   auxRamOff,
  input logic                   codeExtSel,
  input logic                   dataAuxSel,
  input logic                   dataExtSel
);

  localparam logic [CODE_ADDR_W:0] CODE_LIMIT = (CODE_ADDR_W+1)'(ONCHIP_CODE_BYTES);
  localparam logic [DATA_ADDR_W:0] AUX_LIMIT  = (DATA_ADDR_W+1)'(AUX_RAM_BYTES);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeQ)); // R3

  AST_EXT_MODE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |-> codeExtSel); // R1

  AST_CODE_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, fetchAddr} >= CODE_LIMIT) |-> codeExtSel); // R2

  AST_AUX_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !auxRamOff && ({1'b0, dataAddr} < AUX_LIMIT)) |-> (dataAuxSel && !dataExtSel)); // R5

  AST_ABOVE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && ({1'b0, dataAddr} >= AUX_LIMIT)) |-> (dataExtSel && !dataAuxSel)); // R6

  AST_AUX_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && auxRamOff) |-> (dataExtSel && !dataAuxSel)); // R7

  AST_NO_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (!dataAuxSel && !dataExtSel)); // R8

endmodule

bind access_router access_router_chk #(
  .CODE_ADDR_W       (CODE_ADDR_W),
  .DATA_ADDR_W       (DATA_ADDR_W),
  .ONCHIP_CODE_BYTES (ONCHIP_CODE_BYTES),
  .AUX_RAM_BYTES     (AUX_RAM_BYTES)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeQ      (routeStrb.extMode),
  .fetchAddr  (fetchAddr),
  .dataValid  (dataValid),
  .dataAddr   (dataAddr),
  .auxRamOff  (auxRamOff),
  .codeExtSel (codeExtSel),
  .dataAuxSel (dataAuxSel),
  .dataExtSel (dataExtSel)
);

// File: tb/test_access_router.sv
`timescale 1ns/1ps
module test_access_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        extAccessPin = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        dataValid = 1'b0;
  logic [15:0] dataAddr = '0;
  logic        auxRamOff = 1'b0;
  logic        codeExtSel, dataAuxSel, dataExtSel;

  always #2 clk = ~clk;

  access_router i_access_router (
    .clk(clk), .rstN(rstN), .extAccessPin(extAccessPin),
    .fetchAddr(fetchAddr), .dataValid(dataValid), .dataAddr(dataAddr),
    .auxRamOff(auxRamOff), .codeExtSel(codeExtSel),
    .dataAuxSel(dataAuxSel), .dataExtSel(dataExtSel)
  );

  typedef struct {
    logic  code;
    logic  aux;
    logic  ext;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic benchMode = 1'b0;
  logic finished = 1'b0;

  task automatic drive(input logic [15:0] fa, input logic [15:0] da,
                       input logic v, input logic off, input string tag);
    expItem_t it;
    logic inWin;
    @(negedge clk);
    fetchAddr = fa; dataAddr = da; dataValid = v; auxRamOff = off;
    inWin   = (da < 16'd768);
    it.code = benchMode || (fa >= 16'h1000);
    it.aux  = v && inWin && !off;
    it.ext  = v && !(inWin && !off);
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic doReset(input logic pin);
    rstN = 1'b0; extAccessPin = pin; benchMode = pin;
    @(negedge clk);
    @(negedge clk);
    drive(16'h0000, 16'h0000, 1'b0, 1'b0, "R8 reset");
    @(negedge clk);
    rstN = 1'b1;
    extAccessPin = ~pin;  // later pin changes must be ignored (R3)
  endtask

  // monitor: compare outputs a little after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (codeExtSel !== e.code || dataAuxSel !== e.aux || dataExtSel !== e.ext) begin
          errors++;
          $display("FAIL %s: got code=%b aux=%b ext=%b expected code=%b aux=%b ext=%b",
                   e.tag, codeExtSel, dataAuxSel, dataExtSel, e.code, e.aux, e.ext);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // mode clear: on-chip code below 1000H
    doReset(1'b0);
    drive(16'h0000, 16'h0000, 1'b1, 1'b0, "R2 low code");
    drive(16'h0FFF, 16'h02FF, 1'b1, 1'b0, "R2 top on-chip / R5 top of window");
    drive(16'h1000, 16'h0300, 1'b1, 1'b0, "R2 first external / R6 first above window");
    drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R2 top code / R6 top data");
    drive(16'h0FFF, 16'h0000, 1'b1, 1'b1, "R9 back / R7 window disabled");
    drive(16'h1000, 16'h02FF, 1'b1, 1'b1, "R9 forward / R7 window top disabled");
    drive(16'h0100, 16'h0010, 1'b0, 1'b0, "R8 no request / R3 pin ignored");
    drive(16'h0100, 16'h0010, 1'b1, 1'b0, "R3 pin ignored / R5");
    // mode set: everything external for code
    doReset(1'b1);
    drive(16'h0000, 16'h0005, 1'b1, 1'b0, "R1 low code / R4 aux");
    drive(16'h0FFF, 16'h02FF, 1'b1, 1'b0, "R1 top on-chip range / R4 aux");
    drive(16'hFFFF, 16'h0320, 1'b1, 1'b0, "R1 top / R4 external");
    drive(16'h0010, 16'h0001, 1'b1, 1'b1, "R3 pin ignored / R7");
    drive(16'h0800, 16'h0300, 1'b0, 1'b1, "R8 no request");
    // back to mode clear to confirm a fresh capture
    doReset(1'b0);
    drive(16'h0800, 16'h0100, 1'b1, 1'b0, "R3 recapture / R4");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule